// File: doc/BRIEF.md
# I2C Coprocessor Command Front End

This block is the I2C target side of a register-file coprocessor. A host sends instruction and operand bytes to register pointer 0. The bytes are queued in an instruction buffer, and an execution engine drains that buffer. Reading pointer 0 returns a result byte when one is queued. When no result byte is queued, it returns a status code. Pointer 1 serves two purposes: reading it gives the free room in the instruction buffer, and writing zero to it restarts the unit.

A small stub engine stands in for the arithmetic unit. It takes one byte at a time, spends a fixed number of cycles on it and then acts on it. A byte whose bit 7 is 0 is shifted into word 0 of the register file. A byte whose bit 7 is 1 asks for the register selected by its low bits to be queued as four result bytes, most significant byte first. A trace input represents a debug trace buffer that is not yet empty. While the trace input is high, the engine consumes nothing.

SCL and SDA reach the block through synchronizer chains. SDA is driven only by pulling it low through an output enable. The block never stretches the clock.

Top module: `fpc_i2c_front`

## Requirements
- R1: The block acknowledges only the 7-bit target address 1100100. Any other address gets no acknowledge, and the block then stays silent until the next start condition.
- R2: In a write transfer, the first data byte sets the register pointer. The pointer keeps its value for later read transfers.
- R3: Every further byte written while the pointer is 0 is queued in order. The engine acts on each byte in turn. When bit 7 is 0, word 0 becomes (word0 << 8) | byte. When bit 7 is 1, the four bytes of the word indexed by the byte's low bits are queued as results, most significant byte first.
- R4: Each byte read from pointer 0 removes and returns the oldest queued result byte, if there is one.
- R5: When no result byte is queued, a read of pointer 0 returns a status code. The code is 0x00 only when four things hold: the instruction buffer is empty, the engine is idle, the trace input is low and no register clear is running. Otherwise the code is 0x80.
- R6: A read of pointer 1 returns min(255, buffer depth minus buffered byte count).
- R7: A byte written to pointer 0 while the buffer is full gets no acknowledge and is dropped. It also sets the overflow output, which stays high until a restart.
- R8: Writing 0x00 to pointer 1 does the following: it empties both queues, clears the overflow output and returns every 32-bit register to 0x7FC00000, one register per cycle, with status 0x80 while that clear runs. Writing any nonzero value to pointer 1 changes nothing.
- R9: A read of any pointer above 1 returns 0xFF. Writes to such a pointer are acknowledged and have no effect.
- R10: SDA is only ever pulled low. The output enable changes only while the synchronized SCL is low, and it is low after reset.
- R11: While the trace input is high, the instruction buffer is not drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when high |
| trace_busy | input | 1 | High while the debug trace buffer holds data |
| ibuf_overflow | output | 1 | Sticky flag for a dropped instruction byte |

## Verification
The hardest state to reach from the ports is a full instruction buffer, because the engine drains bytes far faster than the bus can deliver them. The bench holds the trace input high, which freezes consumption. It then streams depth plus one bytes in a single write transfer and expects the last byte to be refused. The bench uses a buffer depth slightly above 255. While the buffer fills one byte at a time, the free-space readings sweep from the saturated value 255 into the exact range. Result bytes from register fetches show the effect of the clear sequence, of ignored nonzero writes and of dropped bytes.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
   localparam int          WORD_W      = 32;
   localparam logic [31:0] WORD_QNAN   = 32'h7FC0_0000;
   localparam logic [7:0]  CODE_READY  = 8'h00;
   localparam logic [7:0]  CODE_BUSY   = 8'h80;
   localparam logic [7:0]  CODE_NOREG  = 8'hFF;

   typedef enum logic [2:0] {
      T_IDLE, T_ADDR, T_ADDR_ACK, T_WDATA, T_WDATA_ACK, T_RDATA, T_RDATA_ACK
   } tgt_state_e;

   typedef enum logic [1:0] {
      E_IDLE, E_EXEC, E_EMIT
   } eng_state_e;
endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fpc_fifo.sv
module fpc_fifo #(
   parameter int DEPTH = 256,
   parameter int WIDTH = 8,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign dout    = mem[rd_ptr];

   if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/fpc_engine.sv
module fpc_engine
   import fpc_pkg::*;
#(
   parameter int NREGS       = 8,
   parameter int EXEC_CYCLES = 4,
   localparam int IDXW = $clog2(NREGS),
   localparam int EW   = $clog2(EXEC_CYCLES + 1)
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_rst,
   input  logic       trace_busy,
   input  logic       ib_empty,
   input  logic [7:0] ib_data,
   output logic       ib_pop,
   input  logic       oq_full,
   output logic       oq_push,
   output logic [7:0] oq_data,
   output logic       active,
   output logic       clearing
);
   logic [WORD_W-1:0] rf [NREGS];
   logic [WORD_W-1:0] sel_word, sel_shift;
   eng_state_e        st;
   logic [7:0]        op;
   logic [EW-1:0]     cnt;
   logic [1:0]        emit_n;
   logic [IDXW-1:0]   clr_idx;
   logic              shift_we;

   assign ib_pop    = (st == E_IDLE) & ~ib_empty & ~trace_busy & ~clearing & ~soft_rst;
   assign shift_we  = (st == E_EXEC) & (cnt == '0) & ~op[7];
   assign oq_push   = (st == E_EMIT) & ~oq_full;
   assign sel_word  = rf[op[IDXW-1:0]];
   assign sel_shift = sel_word << {emit_n, 3'b000};
   assign oq_data   = sel_shift[WORD_W-1 -: 8];
   assign active    = (st != E_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) rf[i] <= WORD_QNAN;
      end else if (clearing) begin
         rf[clr_idx] <= WORD_QNAN;
      end else if (shift_we) begin
         rf[0] <= {rf[0][WORD_W-9:0], op};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= E_IDLE;
         op       <= '0;
         cnt      <= '0;
         emit_n   <= '0;
         clearing <= 1'b0;
         clr_idx  <= '0;
      end else if (soft_rst) begin
         st       <= E_IDLE;
         emit_n   <= '0;
         clearing <= 1'b1;
         clr_idx  <= '0;
      end else begin
         if (clearing) begin
            clr_idx <= clr_idx + 1'b1;
            if (clr_idx == IDXW'(NREGS - 1)) clearing <= 1'b0;
         end
         case (st)
            E_IDLE: if (ib_pop) begin
               op  <= ib_data;
               cnt <= EW'(EXEC_CYCLES - 1);
               st  <= E_EXEC;
            end
            E_EXEC: if (cnt == '0) begin
               emit_n <= '0;
               st     <= op[7] ? E_EMIT : E_IDLE;
            end else begin
               cnt <= cnt - 1'b1;
            end
            E_EMIT: if (!oq_full) begin
               emit_n <= emit_n + 1'b1;
               if (emit_n == 2'd3) st <= E_IDLE;
            end
            default: st <= E_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fpc_i2c_tgt.sv
module fpc_i2c_tgt
   import fpc_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1100100
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_s,
   input  logic       sda_s,
   input  logic       ib_full,
   input  logic [7:0] free_byte,
   input  logic [7:0] status_byte,
   input  logic       oq_empty,
   input  logic [7:0] oq_data,
   output logic       oq_pop,
   output logic       ib_push,
   output logic [7:0] ib_wdata,
   output logic       soft_rst,
   output logic       ovf,
   output logic       sda_oe
);
   tgt_state_e st;
   logic       scl_q, sda_q;
   logic       scl_rise, scl_fall, start_c, stop_c;
   logic [7:0] shreg, txsh, ptr, tx_sel;
   logic [3:0] bitcnt;
   logic       done, first, rw, more;
   logic       wbyte_ev, load_tx, wr_ack, data_wr;

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

   always_comb begin
      case (ptr)
         8'd0:    tx_sel = oq_empty ? status_byte : oq_data;
         8'd1:    tx_sel = free_byte;
         default: tx_sel = CODE_NOREG;
      endcase
   end

   assign wbyte_ev = (st == T_WDATA) & scl_fall & done;
   assign data_wr  = wbyte_ev & ~first;
   assign ib_push  = data_wr & (ptr == 8'd0) & ~ib_full;
   assign ib_wdata = shreg;
   assign soft_rst = data_wr & (ptr == 8'd1) & (shreg == 8'd0);
   assign wr_ack   = first | (ptr != 8'd0) | ~ib_full;
   assign load_tx  = scl_fall & (((st == T_ADDR_ACK) & rw) | ((st == T_RDATA_ACK) & more));
   assign oq_pop   = load_tx & (ptr == 8'd0) & ~oq_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf <= 1'b0;
      else if (soft_rst) ovf <= 1'b0;
      else if (data_wr & (ptr == 8'd0) & ib_full) ovf <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
         st     <= T_IDLE;
         shreg  <= '0;
         txsh   <= '0;
         ptr    <= '0;
         bitcnt <= '0;
         done   <= 1'b0;
         first  <= 1'b0;
         rw     <= 1'b0;
         more   <= 1'b0;
         sda_oe <= 1'b0;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
         if (start_c) begin
            st     <= T_ADDR;
            bitcnt <= '0;
            done   <= 1'b0;
            first  <= 1'b1;
            sda_oe <= 1'b0;
         end else if (stop_c) begin
            st     <= T_IDLE;
            done   <= 1'b0;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               T_ADDR, T_WDATA: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                     if (bitcnt == 4'd7) done <= 1'b1;
                  end else if (scl_fall && done) begin
                     done   <= 1'b0;
                     bitcnt <= '0;
                     if (st == T_ADDR) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           sda_oe <= 1'b1;
                           rw     <= shreg[0];
                           st     <= T_ADDR_ACK;
                        end else begin
                           st <= T_IDLE;
                        end
                     end else begin
                        first  <= 1'b0;
                        if (first) ptr <= shreg;
                        sda_oe <= wr_ack;
                        st     <= T_WDATA_ACK;
                     end
                  end
               end
               T_ADDR_ACK, T_RDATA_ACK: begin
                  if (scl_rise && st == T_RDATA_ACK) begin
                     more <= ~sda_s;
                  end else if (scl_fall) begin
                     if (load_tx) begin
                        sda_oe <= ~tx_sel[7];
                        txsh   <= {tx_sel[6:0], 1'b0};
                        bitcnt <= 4'd1;
                        st     <= T_RDATA;
                     end else if (st == T_ADDR_ACK) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        st     <= T_WDATA;
                     end else begin
                        st <= T_IDLE;
                     end
                  end
               end
               T_WDATA_ACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  st     <= T_WDATA;
               end
               T_RDATA: if (scl_fall) begin
                  if (bitcnt == 4'd8) begin
                     sda_oe <= 1'b0;
                     st     <= T_RDATA_ACK;
                  end else begin
                     sda_oe <= ~txsh[7];
                     txsh   <= {txsh[6:0], 1'b0};
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
               default: st <= T_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/fpc_i2c_front.sv
module fpc_i2c_front
   import fpc_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b1100100,
   parameter int         IBUF_DEPTH  = 256,
   parameter int         OQ_DEPTH    = 8,
   parameter int         NREGS       = 8,
   parameter int         EXEC_CYCLES = 4,
   parameter int         SYNC_STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe,
   input  logic trace_busy,
   output logic ibuf_overflow
);
   localparam int IB_CW = $clog2(IBUF_DEPTH + 1);
   localparam int OQ_CW = $clog2(OQ_DEPTH + 1);

   if (IBUF_DEPTH < 2) begin : g_bad_ibuf
      $error("IBUF_DEPTH must be at least 2");
   end
   if (OQ_DEPTH < 4) begin : g_bad_oq
      $error("OQ_DEPTH must hold one full word");
   end
   if (NREGS < 2 || NREGS > 128 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_nregs
      $error("NREGS must be a power of two from 2 to 128");
   end
   if (EXEC_CYCLES < 1) begin : g_bad_exec
      $error("EXEC_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             scl_s, sda_s;
   logic             ib_push, ib_pop, ib_full, ib_empty;
   logic [7:0]       ib_wdata, ib_rdata;
   logic [IB_CW-1:0] ib_count, ib_free;
   logic             oq_push, oq_pop, oq_full, oq_empty;
   logic [7:0]       oq_wdata, oq_rdata;
   logic [OQ_CW-1:0] oq_count;
   logic             soft_rst, eng_active, clearing, busy;
   logic [7:0]       free_byte, status_byte;

   fpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   fpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   assign ib_free = IB_CW'(IBUF_DEPTH) - ib_count;
   if (IB_CW > 8) begin : g_free_sat
      assign free_byte = (ib_free > IB_CW'(255)) ? 8'hFF : ib_free[7:0];
   end else begin : g_free_fit
      assign free_byte = 8'(ib_free);
   end

   assign busy        = ~ib_empty | eng_active | trace_busy | clearing;
   assign status_byte = busy ? CODE_BUSY : CODE_READY;

   fpc_i2c_tgt #(.DEV_ADDR(DEV_ADDR)) u_tgt (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .ib_full(ib_full), .free_byte(free_byte), .status_byte(status_byte),
      .oq_empty(oq_empty), .oq_data(oq_rdata), .oq_pop(oq_pop),
      .ib_push(ib_push), .ib_wdata(ib_wdata), .soft_rst(soft_rst),
      .ovf(ibuf_overflow), .sda_oe(sda_oe));

   fpc_fifo #(.DEPTH(IBUF_DEPTH), .WIDTH(8)) u_ibuf (
      .clk(clk), .rst_n(rst_n), .flush(soft_rst),
      .push(ib_push), .din(ib_wdata), .pop(ib_pop), .dout(ib_rdata),
      .count(ib_count), .full(ib_full), .empty(ib_empty));

   fpc_fifo #(.DEPTH(OQ_DEPTH), .WIDTH(8)) u_oq (
      .clk(clk), .rst_n(rst_n), .flush(soft_rst),
      .push(oq_push), .din(oq_wdata), .pop(oq_pop), .dout(oq_rdata),
      .count(oq_count), .full(oq_full), .empty(oq_empty));

   fpc_engine #(.NREGS(NREGS), .EXEC_CYCLES(EXEC_CYCLES)) u_eng (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .trace_busy(trace_busy),
      .ib_empty(ib_empty), .ib_data(ib_rdata), .ib_pop(ib_pop),
      .oq_full(oq_full), .oq_push(oq_push), .oq_data(oq_wdata),
      .active(eng_active), .clearing(clearing));
endmodule

// File: rtl/fpc_front_chk.sv
module fpc_front_chk #(
   parameter int IBUF_DEPTH = 256,
   parameter int OQ_DEPTH   = 8,
   localparam int IB_CW = $clog2(IBUF_DEPTH + 1),
   localparam int OQ_CW = $clog2(OQ_DEPTH + 1)
)(
   input logic             clk,
   input logic             rst_n,
   input logic             scl_s,
   input logic             sda_oe,
   input logic             trace_busy,
   input logic             soft_rst,
   input logic             ovf,
   input logic             clearing,
   input logic             busy,
   input logic [IB_CW-1:0] ib_count,
   input logic [OQ_CW-1:0] oq_count
);
   AST_OE_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R10
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ib_count <= IB_CW'(IBUF_DEPTH)); // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !soft_rst) |=> ovf); // R7
   AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !ovf); // R8
   AST_BUSY_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clearing |-> busy); // R8
   AST_TRACE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (trace_busy && !soft_rst) |=> ib_count >= $past(ib_count)); // R11
   AST_OQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      oq_count <= OQ_CW'(OQ_DEPTH)); // R4
endmodule

bind fpc_i2c_front fpc_front_chk #(.IBUF_DEPTH(IBUF_DEPTH), .OQ_DEPTH(OQ_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
   .trace_busy(trace_busy), .soft_rst(soft_rst), .ovf(ibuf_overflow),
   .clearing(clearing), .busy(busy), .ib_count(ib_count), .oq_count(oq_count));

// File: tb/tb_fpc_i2c_front.sv
`timescale 1ns/1ps
module tb_fpc_i2c_front;
   localparam int DEPTH = 260;
   localparam int Q     = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_drv = 1'b1;
   logic sda_drv = 1'b1;
   logic trace = 1'b0;
   logic sda_oe, ovf, sda_line;
   int   n_chk = 0;
   int   n_fail = 0;
   logic [7:0] rbuf [8];

   assign sda_line = sda_drv & ~sda_oe;
   always #5 clk = ~clk;

   fpc_i2c_front #(.DEV_ADDR(7'b1100100), .IBUF_DEPTH(DEPTH), .OQ_DEPTH(8),
                   .NREGS(4), .EXEC_CYCLES(3), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
      .sda_oe(sda_oe), .trace_busy(trace), .ibuf_overflow(ovf));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq();
      sda_drv = 1'b0; wq(); scl_drv = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; wq(); scl_drv = 1'b1; wq(); sda_drv = 1'b1; wq();
   endtask

   task automatic put_bit(input logic b);
      sda_drv = b; wq(); scl_drv = 1'b1; wq(); wq(); scl_drv = 1'b0; wq();
   endtask

   task automatic get_bit(output logic b);
      sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq(); b = sda_line; wq(); scl_drv = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      put_bit(~ack);
   endtask

   task automatic write1(input logic [7:0] ptr, input logic [7:0] d, output logic ack_d);
      logic a;
      bus_start();
      send_byte(8'hC8, a);
      send_byte(ptr, a);
      send_byte(d, ack_d);
      bus_stop();
   endtask

   task automatic set_ptr(input logic [7:0] ptr);
      logic a;
      bus_start();
      send_byte(8'hC8, a);
      send_byte(ptr, a);
      bus_stop();
   endtask

   task automatic read_n(input int n);
      logic a;
      logic [7:0] d;
      bus_start();
      send_byte(8'hC9, a);
      for (int i = 0; i < n; i++) begin
         recv_byte(d, i != n - 1);
         rbuf[i] = d;
      end
      bus_stop();
   endtask

   task automatic check_word(input string tag, input logic [31:0] exp);
      read_n(4);
      check(tag, {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, exp);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic a;
      int   acks;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check("R10 reset oe", {31'd0, sda_oe}, 32'd0);
      check("R7 reset overflow", {31'd0, ovf}, 32'd0);

      // R1: a foreign address is refused and the right one answered
      bus_start(); send_byte(8'hCA, a); bus_stop();
      check("R1 foreign address nak", {31'd0, a}, 32'd0);
      bus_start(); send_byte(8'hC8, a); bus_stop();
      check("R1 own address ack", {31'd0, a}, 32'd1);

      // R5: ready code from an idle unit
      set_ptr(8'd0);
      read_n(1);
      check("R5 ready code", {24'd0, rbuf[0]}, 32'h00);

      // R5 R11 R2: trace held alone makes the unit busy; pointer 0 retained
      trace = 1'b1;
      read_n(1);
      check("R5 busy from trace only", {24'd0, rbuf[0]}, 32'h80);

      // R6 sweep: free room while trace holds the buffer (R11)
      for (int k = 0; k < 10; k++) begin
         set_ptr(8'd1);
         read_n(1);
         check("R6 free space", {24'd0, rbuf[0]}, (DEPTH - k > 255) ? 32'd255 : 32'(DEPTH - k));
         write1(8'd0, 8'h01, a);
         check("R3 byte accepted", {31'd0, a}, 32'd1);
      end
      set_ptr(8'd0);
      read_n(1);
      check("R5 busy with queued bytes", {24'd0, rbuf[0]}, 32'h80);
      trace = 1'b0;
      repeat (100) @(negedge clk);
      read_n(1);
      check("R5 ready after drain", {24'd0, rbuf[0]}, 32'h00);

      // R3 R4: fetch word 0 after ten shifted 0x01 bytes, then status follows
      write1(8'd0, 8'h80, a);
      read_n(5);
      check("R4 fetch word0", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'h01010101);
      check("R4 queue empty then status", {24'd0, rbuf[4]}, 32'h00);
      write1(8'd0, 8'h81, a);
      check_word("R3 word1 untouched", 32'h7FC00000);

      // R3: several data bytes in one transfer
      bus_start();
      send_byte(8'hC8, a); send_byte(8'h00, a);
      send_byte(8'h12, a); send_byte(8'h34, a); send_byte(8'h80, a);
      bus_stop();
      check_word("R3 multi byte transfer", 32'h01011234);

      // R9: unmapped pointer
      write1(8'd2, 8'h55, a);
      check("R9 unmapped write ack", {31'd0, a}, 32'd1);
      read_n(1);
      check("R9 unmapped read", {24'd0, rbuf[0]}, 32'hFF);

      // R8: nonzero write to pointer 1 changes nothing
      write1(8'd1, 8'h07, a);
      write1(8'd0, 8'h80, a);
      check_word("R8 nonzero ignored", 32'h01011234);

      // R8: zero write restarts, registers back to quiet NaN
      write1(8'd1, 8'h00, a);
      repeat (20) @(negedge clk);
      write1(8'd0, 8'h80, a);
      check_word("R8 word0 cleared", 32'h7FC00000);
      check("R10 idle oe", {31'd0, sda_oe}, 32'd0);

      // R7: fill to the brim with consumption frozen
      repeat (50) @(negedge clk);
      trace = 1'b1;
      acks = 0;
      bus_start();
      send_byte(8'hC8, a); send_byte(8'h00, a);
      for (int i = 0; i < DEPTH; i++) begin
         send_byte(8'h02, a);
         if (a) acks++;
      end
      send_byte(8'h02, a);
      bus_stop();
      check("R7 all fitting bytes acked", 32'(acks), 32'(DEPTH));
      check("R7 extra byte nak", {31'd0, a}, 32'd0);
      check("R7 overflow set", {31'd0, ovf}, 32'd1);
      set_ptr(8'd1);
      read_n(1);
      check("R6 full free space", {24'd0, rbuf[0]}, 32'd0);
      check("R7 overflow sticky", {31'd0, ovf}, 32'd1);

      // R8: restart clears overflow and flushes the buffer
      write1(8'd1, 8'h00, a);
      repeat (20) @(negedge clk);
      check("R8 overflow cleared", {31'd0, ovf}, 32'd0);
      read_n(1);
      check("R8 flushed free space", {24'd0, rbuf[0]}, 32'd255);
      trace = 1'b0;
      set_ptr(8'd0);
      read_n(1);
      check("R8 ready after restart", {24'd0, rbuf[0]}, 32'h00);
      write1(8'd0, 8'h80, a);
      check_word("R8 dropped bytes not executed", 32'h7FC00000);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule